// File: doc/BRIEF.md
# SPI Host Controller with Register Interface

This block is a register-mapped SPI master. Software uses a simple 32-bit register bus to set up the serial framing: clock polarity, clock phase, bit order, 8- or 16-bit words and the baud divider. After setup it switches the controller from configuration mode to active mode. In active mode it writes words to the data register. They queue in a four-entry transmit buffer and are shifted out on MOSI. For each word, the word captured on MISO at the same time lands in a four-entry receive buffer, and reading the data register pops it. Chip selects are outside the block.

A status register shows both buffer levels, a sticky overrun flag, an idle flag and a receive-threshold flag. The interrupt output is high when the threshold flag is set and its enable bit is on. The register bus has no back-pressure: every read or write completes in the cycle it is presented. Read data is combinational from the address. A read strobe on the data register pops the receive buffer at the clock edge that ends that cycle. Because the bus has no ready signal, flow control is done in software through the level fields and the overrun flag.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the controller is in configuration mode (control register 0x00 reads 0x40), both buffers are empty, status reads 0x0000_0004, SCK is low and `irq` is low.
- R2: Register 0x00 holds the operating mode in bits [7:6], where 01 is configuration and 10 is active. Bit 1 is a stop request that reads back. Bit 0 is a clear request that always reads as 0.
- R3: In register 0x04, bit 0 is polarity, bit 1 is phase and bit 2 selects MSB-first when 1. In register 0x08, bits [15:8] are the divider, and bits [4:0] written as 16 select 16-bit words (any other value selects 8-bit); they read back as 16 or 8. These shape fields change only on writes made in configuration mode. Writes made in active mode leave them unchanged.
- R4: A divider of 0 is stored as 1. Each SCK half-period lasts divider clock cycles.
- R5: Outside active mode, writes to the data register (0x18) are ignored and no shifting takes place. A word already in flight is abandoned, and SCK returns to its idle level.
- R6: SCK idles at the polarity bit. With phase 0, data is sampled on the leading SCK edge and changed on the trailing edge. With phase 1 this is reversed. Bits go out in the order the bit-order field selects.
- R7: Each shifted word stores the word received on MISO during the same transfer in the receive buffer. A read of register 0x18 returns the oldest stored word and pops it.
- R8: Status bit 14 is set while the receive level is greater than the threshold field in bits [13:12] of register 0x04, so the threshold in words is the field value plus one. `irq` is status bit 14 ANDed with enable bit 9 of register 0x04. Both drop once reads bring the level back below the threshold.
- R9: A data write in active mode while the transmit buffer holds 4 words drops the word and sets sticky status bit 7. Writing 1 to status bit 7 clears it.
- R10: While the stop bit is set, no new word starts, and queued words stay in the buffer.
- R11: A write to register 0x00 that selects configuration mode with bit 0 set empties both buffers at that clock edge.
- R12: Status bits [13:11] give the transmit level and bits [10:8] the receive level. Bit 2 is set only when the transmit buffer is empty and the shifter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCK is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; pops the receive buffer when the address is 0x18 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Receive-threshold interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A register write takes effect at the first rising edge after the strobe. The bench drives accesses on falling edges and reads combinational data 1 ns after presenting the address, so every register check sees the state left by the previous access. A queued word starts on the edge after its write, and its first SCK edge comes one divider period later. The word is complete after twice the word length in half-periods. The bench therefore polls the idle bit rather than counting cycles before it reads status levels, the interrupt or received words. A serial monitor samples MOSI on the falling clock edge after each SCK transition that the programmed phase names as the sampling edge. It compares each assembled word against a queue filled by the driver task, and measures the half-period in whole clock cycles between SCK transitions.

// File: rtl/shc_pkg.sv
package shc_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 5;
  localparam int WORD_MAX = 16;
  localparam int DIV_W    = 8;
  localparam int BUF_DEPTH = 4;

  localparam logic [ADDR_W-1:0] A_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] A_SHP0 = 5'h04;
  localparam logic [ADDR_W-1:0] A_SHP1 = 5'h08;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h14;
  localparam logic [ADDR_W-1:0] A_DATA = 5'h18;

  typedef enum logic [1:0] {
    OPM_OFF = 2'b00,
    OPM_CFG = 2'b01,
    OPM_RUN = 2'b10,
    OPM_RSV = 2'b11
  } opmode_e;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             msb_first;
    logic             wide;
    logic [DIV_W-1:0] div;
  } shape_t;
endpackage

// File: rtl/shc_fifo.sv
module shc_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LVL_FULL);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/shc_baud.sv
module shc_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/shc_shifter.sv
module shc_shifter
  import shc_pkg::*;
#(
  parameter int WMAX = WORD_MAX,
  localparam int NARROW = WMAX / 2,
  localparam int EDGE_W = $clog2(2 * WMAX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            hold,
  input  shape_t          shape,
  input  logic            tx_avail,
  input  logic [WMAX-1:0] tx_word,
  output logic            tx_take,
  output logic            rx_put,
  output logic [WMAX-1:0] rx_word,
  output logic            busy,
  output logic            sck,
  output logic            mosi,
  input  logic            miso
);
  logic [WMAX-1:0]   tx_sr, rx_sr, rx_nxt;
  logic [EDGE_W-1:0] edge_cnt, edge_last;
  logic              phase, tick, lead, do_sample, do_shift;

  shc_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (shape.div),
    .tick (tick)
  );

  assign tx_take   = active && !hold && tx_avail && !busy;
  assign edge_last = shape.wide ? EDGE_W'(2 * WMAX - 1) : EDGE_W'(2 * NARROW - 1);
  assign lead      = !edge_cnt[0];
  assign do_sample = shape.cpha ? !lead : lead;
  assign do_shift  = shape.cpha ? (lead && edge_cnt != '0) : !lead;

  always_comb begin
    rx_nxt = rx_sr;
    if (do_sample)
      rx_nxt = shape.msb_first ? {rx_sr[WMAX-2:0], miso} : {miso, rx_sr[WMAX-1:1]};
  end

  always_comb begin
    if (shape.wide)           rx_word = rx_nxt;
    else if (shape.msb_first) rx_word = {{NARROW{1'b0}}, rx_nxt[NARROW-1:0]};
    else                      rx_word = {{NARROW{1'b0}}, rx_nxt[WMAX-1:NARROW]};
  end

  assign rx_put = busy && tick && (edge_cnt == edge_last);
  assign sck    = shape.cpol ^ phase;
  assign mosi   = shape.msb_first ? tx_sr[WMAX-1] : tx_sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= 1'b0;
      edge_cnt <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
    end else if (!active) begin
      busy     <= 1'b0;
      phase    <= 1'b0;
      edge_cnt <= '0;
    end else if (tx_take) begin
      busy     <= 1'b1;
      phase    <= 1'b0;
      edge_cnt <= '0;
      rx_sr    <= '0;
      if (shape.wide)           tx_sr <= tx_word;
      else if (shape.msb_first) tx_sr <= {tx_word[NARROW-1:0], {NARROW{1'b0}}};
      else                      tx_sr <= {{NARROW{1'b0}}, tx_word[NARROW-1:0]};
    end else if (busy && tick) begin
      phase    <= ~phase;
      edge_cnt <= edge_cnt + 1'b1;
      rx_sr    <= rx_nxt;
      if (do_shift)
        tx_sr <= shape.msb_first ? {tx_sr[WMAX-2:0], 1'b0} : {1'b0, tx_sr[WMAX-1:1]};
      if (edge_cnt == edge_last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import shc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int LVL_W = $clog2(BUF_DEPTH + 1);

  opmode_e           opmode;
  logic              stop_req, rx_ie, ovr;
  logic [1:0]        thr;
  shape_t            shape;
  logic              active, buf_clr, thr_hit, idle, busy;
  logic              wr_mode, wr_shp0, wr_shp1, wr_stat, wr_data, rd_data;
  logic              tx_push, tx_take, tx_full, tx_empty;
  logic              rx_put, rx_pop, rx_full, rx_empty;
  logic [WORD_MAX-1:0] tx_head, rx_head, rx_word;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic [DIV_W-1:0]  div_in;

  assign wr_mode = bus_wr && (bus_addr == A_MODE);
  assign wr_shp0 = bus_wr && (bus_addr == A_SHP0);
  assign wr_shp1 = bus_wr && (bus_addr == A_SHP1);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign rd_data = bus_rd && (bus_addr == A_DATA);

  assign active  = (opmode == OPM_RUN);
  assign buf_clr = wr_mode && bus_wdata[0] && (bus_wdata[7:6] == OPM_CFG);
  assign tx_push = wr_data && active;
  assign rx_pop  = rd_data;
  assign div_in  = bus_wdata[15:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opmode          <= OPM_CFG;
      stop_req        <= 1'b0;
      thr             <= 2'd0;
      rx_ie           <= 1'b0;
      ovr             <= 1'b0;
      shape.cpol      <= 1'b0;
      shape.cpha      <= 1'b0;
      shape.msb_first <= 1'b1;
      shape.wide      <= 1'b0;
      shape.div       <= DIV_W'(1);
    end else begin
      if (wr_mode) begin
        opmode   <= opmode_e'(bus_wdata[7:6]);
        stop_req <= bus_wdata[1];
      end
      if (wr_shp0) begin
        thr   <= bus_wdata[13:12];
        rx_ie <= bus_wdata[9];
        if (!active) begin
          shape.cpol      <= bus_wdata[0];
          shape.cpha      <= bus_wdata[1];
          shape.msb_first <= bus_wdata[2];
        end
      end
      if (wr_shp1 && !active) begin
        shape.div  <= (div_in == '0) ? DIV_W'(1) : div_in;
        shape.wide <= (bus_wdata[4:0] == 5'd16);
      end
      if (tx_push && tx_full)            ovr <= 1'b1;
      else if (wr_stat && bus_wdata[7])  ovr <= 1'b0;
    end
  end

  shc_fifo #(.WIDTH(WORD_MAX), .DEPTH(BUF_DEPTH)) u_txbuf (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (buf_clr),
    .push (tx_push),
    .din  (bus_wdata[WORD_MAX-1:0]),
    .pop  (tx_take),
    .head (tx_head),
    .level(tx_lvl),
    .full (tx_full),
    .empty(tx_empty)
  );

  shc_fifo #(.WIDTH(WORD_MAX), .DEPTH(BUF_DEPTH)) u_rxbuf (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (buf_clr),
    .push (rx_put),
    .din  (rx_word),
    .pop  (rx_pop),
    .head (rx_head),
    .level(rx_lvl),
    .full (rx_full),
    .empty(rx_empty)
  );

  shc_shifter #(.WMAX(WORD_MAX)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .hold    (stop_req),
    .shape   (shape),
    .tx_avail(!tx_empty),
    .tx_word (tx_head),
    .tx_take (tx_take),
    .rx_put  (rx_put),
    .rx_word (rx_word),
    .busy    (busy),
    .sck     (sck),
    .mosi    (mosi),
    .miso    (miso)
  );

  assign thr_hit = (rx_lvl > {1'b0, thr});
  assign irq     = thr_hit && rx_ie;
  assign idle    = tx_empty && !busy;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE: begin
        bus_rdata[7:6] = opmode;
        bus_rdata[1]   = stop_req;
      end
      A_SHP0: begin
        bus_rdata[13:12] = thr;
        bus_rdata[9]     = rx_ie;
        bus_rdata[2:0]   = {shape.msb_first, shape.cpha, shape.cpol};
      end
      A_SHP1: begin
        bus_rdata[15:8] = shape.div;
        bus_rdata[4:0]  = shape.wide ? 5'd16 : 5'd8;
      end
      A_STAT: begin
        bus_rdata[14]    = thr_hit;
        bus_rdata[13:11] = tx_lvl;
        bus_rdata[10:8]  = rx_lvl;
        bus_rdata[7]     = ovr;
        bus_rdata[2]     = idle;
      end
      A_DATA:  bus_rdata[WORD_MAX-1:0] = rx_empty ? '0 : rx_head;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/shc_chk.sv
module shc_chk
  import shc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic              busy,
  input logic              cpol,
  input logic              sck,
  input logic              irq,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              tx_full,
  input logic              ovr,
  input logic [2:0]        tx_lvl,
  input logic [2:0]        rx_lvl
);
  // R12
  tx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= 3'(BUF_DEPTH));

  // R8
  irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_lvl != 3'd0));

  // R9
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA && active && tx_full) |=> ovr);

  // R5
  cfg_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA && !active) |=> $stable(tx_lvl));

  // R5
  cfg_sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && $past(!active)) |-> (sck == cpol));

  // R6
  idle_sck_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !busy) |-> (sck == cpol));
endmodule

bind spi_host_ctrl shc_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .active  (active),
  .busy    (busy),
  .cpol    (shape.cpol),
  .sck     (sck),
  .irq     (irq),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .tx_full (tx_full),
  .ovr     (ovr),
  .tx_lvl  (tx_lvl),
  .rx_lvl  (rx_lvl)
);

// File: tb/spi_host_ctrl_tb_top.sv
module spi_host_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_MODE = 5'h00, A_SHP0 = 5'h04, A_SHP1 = 5'h08,
                         A_STAT = 5'h14, A_DATA = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq, sck, mosi, miso;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [15:0] exp_tx[$];
  logic [15:0] exp_rx[$];

  logic m_cpol = 0, m_cpha = 0, m_msbf = 1, m_w16 = 0, mon_en = 0;
  int   m_bits = 0;
  logic [15:0] m_word = '0;
  logic sck_q = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso = ~mosi;

  spi_host_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic configure(input logic pol, input logic pha, input logic msbf,
                           input logic w16, input logic [7:0] div, input logic [31:0] cr0_hi);
    mon_en = 0;
    bus_write(A_MODE, 32'h41);
    bus_write(A_SHP0, cr0_hi | {29'd0, msbf, pha, pol});
    bus_write(A_SHP1, {16'd0, div, 3'd0, w16 ? 5'd16 : 5'd8});
    m_cpol = pol; m_cpha = pha; m_msbf = msbf; m_w16 = w16;
    m_bits = 0; m_word = '0;
    sck_q = sck;
    mon_en = 1;
  endtask

  task automatic send(input logic [15:0] w);
    logic [15:0] m;
    m = m_w16 ? 16'hFFFF : 16'h00FF;
    exp_tx.push_back(w & m);
    exp_rx.push_back(~w & m);
    bus_write(A_DATA, {16'd0, w});
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      bus_read(A_STAT, s);
      if (s[2]) break;
    end
  endtask

  task automatic read_rx(input string tag);
    logic [31:0] d;
    logic [15:0] e;
    bus_read(A_DATA, d);
    e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 16'hxxxx;
    check(tag, d, {16'd0, e});
  endtask

  // serial monitor: assembles MOSI bits on the programmed sampling edge
  always @(negedge clk) begin
    if (rst_n && mon_en && (sck !== sck_q)) begin
      if ((sck != m_cpol) ^ m_cpha) begin
        if (m_msbf) m_word = {m_word[14:0], mosi};
        else        m_word[m_bits] = mosi;
        m_bits++;
        if (m_bits == (m_w16 ? 16 : 8)) begin
          if (exp_tx.size() == 0) check("R6 unexpected serial word", {16'd0, m_word}, 32'hFFFF_FFFF);
          else                    check("R6 serial word", {16'd0, m_word}, {16'd0, exp_tx.pop_front()});
          m_bits = 0; m_word = '0;
        end
      end
    end
    sck_q = sck;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c;
    logic s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_read(A_MODE, v);  check("R1 mode after reset", v, 32'h40);
    bus_read(A_STAT, v);  check("R1 status after reset", v, 32'h4);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 sck after reset", {31'd0, sck}, 32'd0);

    // mode 0, MSB first, 8-bit, divider 3
    configure(0, 0, 1, 0, 8'd3, 32'h0);
    bus_read(A_SHP1, v);  check("R3 shape1 readback", v, 32'h0308);
    bus_read(A_SHP0, v);  check("R3 shape0 readback", v, 32'h4);
    bus_write(A_DATA, 32'hAA);
    bus_read(A_STAT, v);  check("R5 data write in config ignored", v, 32'h4);
    bus_write(A_MODE, 32'h80);
    bus_read(A_MODE, v);  check("R2 active mode readback", v, 32'h80);
    bus_write(A_SHP1, 32'h0510);
    bus_read(A_SHP1, v);  check("R3 shape1 write in active ignored", v, 32'h0308);
    send(16'h3C);
    s0 = sck;
    while (sck == s0) @(negedge clk);
    s0 = sck; c = 0;
    while (sck == s0) begin @(negedge clk); c++; end
    check("R4 half-period cycles", c, 32'd3);
    send(16'hA5);
    wait_idle();
    bus_read(A_STAT, v);  check("R12 status after two words", v, 32'h4204);
    read_rx("R7 rx word 1");
    read_rx("R7 rx word 2");

    // mode 3, LSB first, 16-bit, divider 1
    configure(1, 1, 0, 1, 8'd1, 32'h0);
    check("R6 sck idles at polarity 1", {31'd0, sck}, 32'd1);
    bus_write(A_MODE, 32'h80);
    send(16'h1234);
    send(16'hBEEF);
    bus_read(A_STAT, v);  check("R12 idle bit low while shifting", {29'd0, v[2:0]}, 32'd0);
    wait_idle();
    read_rx("R7 rx wide word 1");
    read_rx("R7 rx wide word 2");

    // divider clamp
    configure(0, 0, 1, 0, 8'd1, 32'h0);
    bus_write(A_SHP1, 32'h0010);
    bus_read(A_SHP1, v);  check("R4 divider 0 clamps to 1", v, 32'h0110);

    // receive threshold of 3 words, interrupt enabled
    configure(0, 1, 1, 0, 8'd1, 32'h2200);
    bus_write(A_MODE, 32'h80);
    send(16'h11);
    send(16'h22);
    wait_idle();
    check("R8 irq low below threshold", {31'd0, irq}, 32'd0);
    send(16'h33);
    wait_idle();
    check("R8 irq at threshold", {31'd0, irq}, 32'd1);
    bus_read(A_STAT, v);  check("R8 threshold status bit", {17'd0, v[14], 14'd0}, 32'h4000);
    read_rx("R7 rx thr word 1");
    check("R8 irq drops after pop", {31'd0, irq}, 32'd0);
    read_rx("R7 rx thr word 2");
    read_rx("R7 rx thr word 3");

    // stop request holds shifting; overrun; buffer clear
    bus_write(A_MODE, 32'h82);
    for (int i = 0; i < 5; i++) bus_write(A_DATA, 32'h50 + i);
    repeat (40) @(negedge clk);
    bus_read(A_STAT, v);  check("R10 R9 words held and overrun set", v, 32'h2080);
    bus_write(A_STAT, 32'h80);
    bus_read(A_STAT, v);  check("R9 overrun cleared by write 1", v, 32'h2000);
    bus_write(A_MODE, 32'h41);
    bus_read(A_STAT, v);  check("R11 buffers cleared", v, 32'h4);
    bus_read(A_MODE, v);  check("R2 clear bit reads zero", v, 32'h40);

    check("R6 all serial words seen", exp_tx.size(), 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule